// File: doc/BRIEF.md
# Pulse-Width Single-Wire Byte Receiver

This block listens to a single open-drain wire that idles high and recovers bytes from it. It sees the wire as a synchronised level, sampled once per tick enable. It tells the bits apart by how long the line stays high. A short high pulse is a zero and a pulse about three times as long is a one. Every bit is followed by a low interval. A one-tick low separates two bits, a longer low closes a byte, and a long release ends the message.

Each byte arrives as ten bits: the upper data nibble, its even-parity bit, the lower data nibble, and its even-parity bit. Parity is checked as soon as each nibble's parity bit lands, so a corrupted upper nibble is reported while the rest of the byte is still on the wire. The block holds back the most recently completed byte until it knows whether more bytes follow. It can then mark the final byte of a message. With the checksum option enabled, that final byte is checked as a CRC-8 over the bytes before it.

On a parity or framing error in the middle of a message, the receiver pulls the wire low for a fixed time to tell the sender to give up. It then ignores everything until the wire has idled long enough to end the message.

Top module: `pwrx_line_rx`

## Requirements
- R1: After reset, byte_valid, byte_last, err_parity, err_frame, err_crc and pull_low are all low.
- R2: A high interval of 1 or 2 ticks decodes as a 0 bit and one of 3 or 4 ticks decodes as a 1 bit. Each bit ends when the line goes low.
- R3: A byte frame is 10 bits in this order: data[7:4] MSB first, an even-parity bit over data[7:4], data[3:0] MSB first, and an even-parity bit over data[3:0]. A good frame is delivered on byte_data with its original bit order.
- R4: If the fifth bit does not give even parity with the four bits before it, err_parity pulses at that bit, before any later bit of the byte arrives.
- R5: If the tenth bit does not give even parity with bits 6 to 9, err_parity pulses and the byte is never delivered.
- R6: A falling edge from idle starts a message, and its first low (up to 4 ticks) is not a bit. After a bit, a low of 1 tick separates bits and a low of 2 to 4 ticks is a byte boundary. A boundary reached with other than 10 bits, or an eleventh bit before a boundary, raises err_frame.
- R7: A high interval of 8 ticks ends the message. Every good byte is delivered exactly once and in order, with byte_last set only on the final byte. A byte is released when the next byte completes or when the message ends.
- R8: A high interval of 5 to 7 ticks that ends in a falling edge, or a low interval longer than 4 ticks, raises err_frame.
- R9: An err_parity or err_frame inside a message turns on pull_low in the same cycle as the flag, for exactly 4 ticks. No byte is delivered after that, and the held byte is dropped, until the message has ended.
- R10: With the checksum option on, err_crc pulses together with the final byte when that byte differs from the CRC-8 of the earlier bytes. The CRC-8 uses polynomial 0x07, a zero start value and MSB-first processing.
- R11: If the message ends with 1 to 9 bits received after the last boundary, err_frame pulses, pull_low stays low and no byte is delivered for that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-unit enable; the line is sampled when high |
| line_in | input | 1 | Synchronised wire level |
| byte_valid | output | 1 | One-cycle strobe for a delivered byte |
| byte_data | output | 8 | Delivered byte |
| byte_last | output | 1 | Delivered byte is the final byte of the message |
| err_parity | output | 1 | One-cycle pulse on a nibble parity failure |
| err_frame | output | 1 | One-cycle pulse on a timing or bit-count failure |
| err_crc | output | 1 | One-cycle pulse on a checksum mismatch, with the final byte |
| pull_low | output | 1 | Drive the wire low (error response) |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, decode limits of 2 and 4 ticks, a 1-tick separator, boundaries of up to 4 ticks, an 8-tick end-of-message threshold, a 4-tick pull and the checksum enabled. It drives ticks every fourth clock. These small values let one message carry all 256 byte values followed by their CRC. Along the way the pulse widths alternate between both legal widths of each bit value. Short scripted messages then cover each kind of error: upper-nibble and lower-nibble parity, short and long bit counts, overlong high and low intervals, and truncation at end of message. Each of these is followed by a clean message to show the receiver recovers.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;

   // Tick-level events produced by the line timer
   typedef struct packed {
      logic start;     // falling edge out of idle
      logic bit_ev;    // a bit-length high interval just ended
      logic bit_val;   // its decoded value
      logic gap;       // a byte-boundary low just ended
      logic long_hi;   // high interval too long for a bit, too short for idle
      logic long_lo;   // low interval exceeded the boundary limit
      logic eom;       // idle threshold reached inside a message
   } line_ev_t;

   function automatic logic [7:0] crc8_step(input logic [7:0] acc,
                                            input logic [7:0] din,
                                            input logic [7:0] poly);
      logic [7:0] x;
      x = acc ^ din;
      for (int i = 0; i < 8; i++)
         x = x[7] ? ({x[6:0], 1'b0} ^ poly) : {x[6:0], 1'b0};
      return x;
   endfunction

endpackage

// File: rtl/pwrx_timer.sv
module pwrx_timer
   import pwrx_pkg::*;
#(
   parameter int ZERO_MAX  = 2,
   parameter int ONE_MAX   = 4,
   parameter int SEP_MAX   = 1,
   parameter int GAP_MAX   = 4,
   parameter int EOM_UNITS = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     line,
   output line_ev_t ev,
   output logic     in_msg
);

   localparam int CNT_MAX = (EOM_UNITS > GAP_MAX + 1) ? EOM_UNITS : GAP_MAX + 1;
   localparam int CW      = $clog2(CNT_MAX + 1);

   localparam logic [CW-1:0] K_ZERO = CW'(ZERO_MAX);
   localparam logic [CW-1:0] K_ONE  = CW'(ONE_MAX);
   localparam logic [CW-1:0] K_SEP  = CW'(SEP_MAX);
   localparam logic [CW-1:0] K_GAP  = CW'(GAP_MAX);
   localparam logic [CW-1:0] K_EOM1 = CW'(EOM_UNITS - 1);
   localparam logic [CW-1:0] K_MAX  = CW'(CNT_MAX);
   localparam logic [CW-1:0] K_1    = CW'(1);

   logic          prev_lvl;
   logic          start_low;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] lo_cnt;
   logic          fall;
   logic          rise;

   always_comb begin
      fall = prev_lvl & ~line;
      rise = ~prev_lvl & line;
      ev   = '0;
      if (tick) begin
         ev.start   = fall & ~in_msg;
         ev.bit_ev  = fall & in_msg & (hi_cnt <= K_ONE);
         ev.bit_val = hi_cnt > K_ZERO;
         ev.long_hi = fall & in_msg & (hi_cnt > K_ONE);
         ev.gap     = rise & in_msg & ~start_low & (lo_cnt > K_SEP) & (lo_cnt <= K_GAP);
         ev.long_lo = ~line & ~fall & in_msg & (lo_cnt == K_GAP);
         ev.eom     = line & ~rise & in_msg & (hi_cnt == K_EOM1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl  <= 1'b1;
         hi_cnt    <= K_MAX;
         lo_cnt    <= '0;
         in_msg    <= 1'b0;
         start_low <= 1'b0;
      end else if (tick) begin
         prev_lvl <= line;
         if (line) begin
            if (rise) begin
               hi_cnt    <= K_1;
               start_low <= 1'b0;
            end else if (hi_cnt != K_MAX) begin
               hi_cnt <= hi_cnt + K_1;
            end
         end else begin
            if (fall)                 lo_cnt <= K_1;
            else if (lo_cnt != K_MAX) lo_cnt <= lo_cnt + K_1;
         end
         if (ev.start) begin
            in_msg    <= 1'b1;
            start_low <= 1'b1;
         end else if (ev.eom) begin
            in_msg <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pwrx_framer.sv
module pwrx_framer #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               bit_ev,
   input  logic               bit_val,
   input  logic               gap,
   output logic               par_err,
   output logic               over_err,
   output logic               cnt_err,
   output logic               byte_done,
   output logic               partial,
   output logic [2*NIB_W-1:0] data
);

   localparam int FB = 2 * NIB_W + 2;
   localparam int BW = $clog2(FB + 1);

   localparam logic [BW-1:0] K_FB   = BW'(FB);
   localparam logic [BW-1:0] K_P1   = BW'(NIB_W);
   localparam logic [BW-1:0] K_P2   = BW'(FB - 1);
   localparam logic [BW-1:0] K_STEP = BW'(1);

   logic [BW-1:0] bit_cnt;
   logic [FB-1:0] shreg;
   logic          at_parity;

   always_comb begin
      at_parity = (bit_cnt == K_P1) | (bit_cnt == K_P2);
      par_err   = bit_ev & at_parity & (^{shreg[NIB_W-1:0], bit_val});
      over_err  = bit_ev & (bit_cnt == K_FB);
      byte_done = gap & (bit_cnt == K_FB);
      cnt_err   = gap & (bit_cnt != K_FB);
      partial   = bit_cnt != '0;
      data      = {shreg[FB-1 -: NIB_W], shreg[NIB_W -: NIB_W]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (clr || gap) begin
         bit_cnt <= '0;
      end else if (bit_ev && bit_cnt != K_FB) begin
         shreg   <= {shreg[FB-2:0], bit_val};
         bit_cnt <= bit_cnt + K_STEP;
      end
   end

endmodule

// File: rtl/pwrx_crc8.sv
module pwrx_crc8
   import pwrx_pkg::*;
#(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       upd,
   input  logic [7:0] din,
   output logic       residue_bad
);

   logic [7:0] acc;

   assign residue_bad = acc != 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= 8'h00;
      else if (clr) acc <= 8'h00;
      else if (upd) acc <= crc8_step(acc, din, POLY);
   end

endmodule

// File: rtl/pwrx_line_rx.sv
module pwrx_line_rx
   import pwrx_pkg::*;
#(
   parameter int         NIB_W      = 4,
   parameter int         ZERO_MAX   = 2,
   parameter int         ONE_MAX    = 4,
   parameter int         SEP_MAX    = 1,
   parameter int         GAP_MAX    = 4,
   parameter int         EOM_UNITS  = 8,
   parameter int         PULL_UNITS = 4,
   parameter bit         CRC_EN     = 1'b1,
   parameter logic [7:0] CRC_POLY   = 8'h07
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               line_in,
   output logic               byte_valid,
   output logic [2*NIB_W-1:0] byte_data,
   output logic               byte_last,
   output logic               err_parity,
   output logic               err_frame,
   output logic               err_crc,
   output logic               pull_low
);

   localparam int DW = 2 * NIB_W;
   localparam int PW = $clog2(PULL_UNITS + 1);
   localparam logic [PW-1:0] K_PULL = PW'(PULL_UNITS);
   localparam logic [PW-1:0] K_DEC  = PW'(1);

   // elaboration-time parameter checks
   if (NIB_W < 1) begin : g_bad_nib
      $error("NIB_W must be at least 1");
   end
   if (ZERO_MAX < 1 || ONE_MAX <= ZERO_MAX) begin : g_bad_bit
      $error("bit width limits must satisfy 1 <= ZERO_MAX < ONE_MAX");
   end
   if (SEP_MAX < 1 || GAP_MAX <= SEP_MAX) begin : g_bad_gap
      $error("low limits must satisfy 1 <= SEP_MAX < GAP_MAX");
   end
   if (EOM_UNITS <= ONE_MAX + 1) begin : g_bad_eom
      $error("EOM_UNITS must exceed ONE_MAX + 1");
   end
   if (PULL_UNITS < 1) begin : g_bad_pull
      $error("PULL_UNITS must be at least 1");
   end
   if (CRC_EN && DW != 8) begin : g_bad_crc
      $error("checksum option needs 8-bit bytes");
   end

   line_ev_t          ev;
   logic              in_msg;
   logic              f_par, f_over, f_cnt, f_done, f_partial;
   logic [DW-1:0]     f_data;
   logic              crc_bad;
   logic              discard;
   logic [PW-1:0]     pull_cnt;
   logic              pend_v;
   logic [DW-1:0]     pend_d;
   logic              abort, tail_bad, accept, finish, frame_now;

   pwrx_timer #(
      .ZERO_MAX (ZERO_MAX),
      .ONE_MAX  (ONE_MAX),
      .SEP_MAX  (SEP_MAX),
      .GAP_MAX  (GAP_MAX),
      .EOM_UNITS(EOM_UNITS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .line  (line_in),
      .ev    (ev),
      .in_msg(in_msg)
   );

   pwrx_framer #(.NIB_W(NIB_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ev.start | ev.eom),
      .bit_ev   (ev.bit_ev),
      .bit_val  (ev.bit_val),
      .gap      (ev.gap),
      .par_err  (f_par),
      .over_err (f_over),
      .cnt_err  (f_cnt),
      .byte_done(f_done),
      .partial  (f_partial),
      .data     (f_data)
   );

   if (CRC_EN) begin : g_crc
      pwrx_crc8 #(.POLY(CRC_POLY)) u_crc (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (ev.start | ev.eom),
         .upd        (accept),
         .din        (f_data),
         .residue_bad(crc_bad)
      );
   end else begin : g_nocrc
      assign crc_bad = 1'b0;
   end

   always_comb begin
      frame_now = f_over | f_cnt | ev.long_hi | ev.long_lo;
      abort     = ~discard & (f_par | frame_now);
      tail_bad  = ~discard & ev.eom & f_partial;
      accept    = ~discard & f_done;
      finish    = ~discard & ev.eom & ~f_partial & pend_v;
   end

   assign pull_low = pull_cnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         discard    <= 1'b0;
         pull_cnt   <= '0;
         pend_v     <= 1'b0;
         pend_d     <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
         byte_last  <= 1'b0;
         err_parity <= 1'b0;
         err_frame  <= 1'b0;
         err_crc    <= 1'b0;
      end else begin
         byte_valid <= (accept & pend_v) | finish;
         byte_data  <= pend_d;
         byte_last  <= finish;
         err_crc    <= finish & crc_bad;
         err_parity <= ~discard & f_par;
         err_frame  <= (~discard & frame_now) | tail_bad;

         if (abort || ev.eom || ev.start) begin
            pend_v <= 1'b0;
         end else if (accept) begin
            pend_v <= 1'b1;
            pend_d <= f_data;
         end

         if (ev.eom)     discard <= 1'b0;
         else if (abort) discard <= 1'b1;

         if (abort)                      pull_cnt <= K_PULL;
         else if (tick && pull_cnt != '0) pull_cnt <= pull_cnt - K_DEC;
      end
   end

endmodule

// File: rtl/pwrx_line_rx_chk.sv
module pwrx_line_rx_chk #(
   parameter int PULL_UNITS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic pull_low,
   input logic byte_valid,
   input logic byte_last,
   input logic err_parity,
   input logic err_frame,
   input logic err_crc
);

   localparam int PW = $clog2(PULL_UNITS + 2);
   localparam logic [PW-1:0] K_PULL = PW'(PULL_UNITS);

   logic [PW-1:0] pull_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pull_ticks <= '0;
      else if (!pull_low) pull_ticks <= '0;
      else if (tick)      pull_ticks <= pull_ticks + PW'(1);
   end

   // R9
   pull_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_low) |-> (err_parity || err_frame));

   // R9
   pull_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull_ticks <= K_PULL);

   // R9
   pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_low) |-> (pull_ticks == K_PULL));

   // R9
   quiet_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> !byte_valid);

   // R7
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_last |-> byte_valid);

   // R10
   crc_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_crc |-> (byte_valid && byte_last));

   // R5
   par_nobyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_parity |-> !byte_valid);

endmodule

bind pwrx_line_rx pwrx_line_rx_chk #(.PULL_UNITS(PULL_UNITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .pull_low  (pull_low),
   .byte_valid(byte_valid),
   .byte_last (byte_last),
   .err_parity(err_parity),
   .err_frame (err_frame),
   .err_crc   (err_crc)
);

// File: tb/pwrx_line_rx_test.sv
module pwrx_line_rx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick;
   logic [1:0] div;
   logic       tx_low = 1'b0;
   logic       line_in;
   logic       byte_valid, byte_last, err_parity, err_frame, err_crc, pull_low;
   logic [7:0] byte_data;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [7:0] rx_d [0:511];
   logic       rx_l [0:511];
   int n_rx = 0, n_par = 0, n_frm = 0, n_crc = 0, pull_cyc = 0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) div <= '0;
      else        div <= div + 2'd1;
   end
   assign tick    = div == 2'd3;
   assign line_in = ~(tx_low | pull_low);

   pwrx_line_rx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .line_in   (line_in),
      .byte_valid(byte_valid),
      .byte_data (byte_data),
      .byte_last (byte_last),
      .err_parity(err_parity),
      .err_frame (err_frame),
      .err_crc   (err_crc),
      .pull_low  (pull_low)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid && n_rx < 512) begin
            rx_d[n_rx] = byte_data;
            rx_l[n_rx] = byte_last;
            n_rx++;
         end
         if (err_parity) n_par++;
         if (err_frame)  n_frm++;
         if (err_crc)    n_crc++;
         if (pull_low)   pull_cyc++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic logic [7:0] crc_next(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] x = c ^ d;
      for (int i = 0; i < 8; i++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
      return x;
   endfunction

   function automatic logic [9:0] mk_frame(input logic [7:0] d, input bit bad1, input bit bad2);
      return {d[7:4], (^d[7:4]) ^ bad1, d[3:0], (^d[3:0]) ^ bad2};
   endfunction

   // hold the line at lvl for n tick samples; entered and left just after a falling clock edge
   task automatic hold(input bit lvl, input int n);
      int k = 0;
      tx_low = ~lvl;
      while (k < n) begin
         if (tick) k++;
         @(negedge clk);
      end
   endtask

   task automatic send_bits(input logic [9:0] f, input int nb, input int ph, input int tail_low);
      for (int i = 0; i < nb; i++) begin
         int w;
         w = f[9-i] ? 3 + ((i + ph) & 1) : 1 + ((i + ph) & 1);
         hold(1'b1, w);
         hold(1'b0, (i == nb - 1) ? tail_low : 1);
      end
   endtask

   task automatic send_byte(input logic [7:0] d, input int ph);
      send_bits(mk_frame(d, 1'b0, 1'b0), 10, ph, 3);
   endtask

   task automatic settle();
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int b_rx, b_par, b_frm, b_crc, b_pull;
      logic [7:0] c;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk_eq("R1 byte_valid", byte_valid, 0);
      chk_eq("R1 byte_last", byte_last, 0);
      chk_eq("R1 err_parity", err_parity, 0);
      chk_eq("R1 err_frame", err_frame, 0);
      chk_eq("R1 err_crc", err_crc, 0);
      chk_eq("R1 pull_low", pull_low, 0);

      // R2 R3 R7 R10: all 256 values with alternating widths, then the checksum
      b_rx = n_rx; b_par = n_par; b_frm = n_frm; b_crc = n_crc; b_pull = pull_cyc;
      c = 8'h00;
      hold(1'b0, 2);
      for (int d = 0; d < 256; d++) begin
         send_byte(8'(d), d);
         c = crc_next(c, 8'(d));
      end
      send_byte(c, 1);
      hold(1'b1, 12);
      settle();
      chk_eq("R7 byte count", n_rx - b_rx, 257);
      for (int i = 0; i < 257; i++) begin
         int e;
         e = (i < 256) ? i : int'(c);
         chk_eq("R2 R3 byte value", int'(rx_d[b_rx + i]), e);
         chk_eq("R7 last marker", int'(rx_l[b_rx + i]), (i == 256) ? 1 : 0);
      end
      chk_eq("R10 good checksum", n_crc - b_crc, 0);
      chk_eq("R6 no frame error", n_frm - b_frm, 0);
      chk_eq("R3 no parity error", n_par - b_par, 0);
      chk_eq("R9 no pull", pull_cyc - b_pull, 0);

      // R10 wrong checksum
      b_rx = n_rx; b_crc = n_crc;
      c = crc_next(crc_next(8'h00, 8'hA5), 8'h3C);
      hold(1'b0, 2);
      send_byte(8'hA5, 0);
      send_byte(8'h3C, 1);
      send_byte(c ^ 8'h01, 0);
      hold(1'b1, 12);
      settle();
      chk_eq("R10 bytes with bad checksum", n_rx - b_rx, 3);
      chk_eq("R10 checksum flag", n_crc - b_crc, 1);
      chk_eq("R7 last on third", int'(rx_l[b_rx + 2]), 1);

      // R4 upper-nibble parity flagged after five bits
      b_rx = n_rx; b_par = n_par; b_frm = n_frm; b_pull = pull_cyc;
      hold(1'b0, 2);
      send_byte(8'h11, 0);
      send_bits(mk_frame(8'h5A, 1'b1, 1'b0), 5, 0, 1);
      settle();
      chk_eq("R4 early parity flag", n_par - b_par, 1);
      hold(1'b1, 20);
      settle();
      chk_eq("R9 pull length cycles", pull_cyc - b_pull, 16);
      chk_eq("R9 held byte dropped", n_rx - b_rx, 0);
      chk_eq("R4 no frame flag", n_frm - b_frm, 0);

      // R5 lower-nibble parity, sender keeps going
      b_rx = n_rx; b_par = n_par; b_pull = pull_cyc;
      hold(1'b0, 2);
      send_byte(8'h77, 0);
      send_bits(mk_frame(8'hC3, 1'b0, 1'b1), 10, 1, 3);
      send_byte(8'h42, 0);
      hold(1'b1, 12);
      settle();
      chk_eq("R5 parity flag", n_par - b_par, 1);
      chk_eq("R9 nothing delivered", n_rx - b_rx, 0);
      chk_eq("R9 pull length cycles", pull_cyc - b_pull, 16);

      // R9 recovery after the idle
      b_rx = n_rx; b_crc = n_crc;
      c = crc_next(crc_next(8'h00, 8'h81), 8'h7E);
      hold(1'b0, 2);
      send_byte(8'h81, 1);
      send_byte(8'h7E, 0);
      send_byte(c, 1);
      hold(1'b1, 12);
      settle();
      chk_eq("R9 recovered count", n_rx - b_rx, 3);
      chk_eq("R9 recovered byte", int'(rx_d[b_rx]), 8'h81);
      chk_eq("R7 recovered last", int'(rx_l[b_rx + 2]), 1);
      chk_eq("R10 recovered checksum", n_crc - b_crc, 0);

      // R6 nine bits before a boundary
      b_frm = n_frm; b_pull = pull_cyc;
      hold(1'b0, 2);
      send_bits(mk_frame(8'h96, 1'b0, 1'b0), 9, 0, 3);
      hold(1'b1, 20);
      settle();
      chk_eq("R6 short byte", n_frm - b_frm, 1);
      chk_eq("R9 pull after short byte", pull_cyc - b_pull, 16);

      // R6 eleven bits before a boundary
      b_frm = n_frm;
      hold(1'b0, 2);
      send_bits(mk_frame(8'h2D, 1'b0, 1'b0), 10, 0, 1);
      hold(1'b1, 1);
      hold(1'b0, 3);
      hold(1'b1, 20);
      settle();
      chk_eq("R6 long byte", n_frm - b_frm, 1);

      // R8 overlong high
      b_frm = n_frm;
      hold(1'b0, 2);
      hold(1'b1, 6);
      hold(1'b0, 1);
      hold(1'b1, 20);
      settle();
      chk_eq("R8 long high", n_frm - b_frm, 1);

      // R8 overlong low
      b_frm = n_frm;
      hold(1'b0, 2);
      hold(1'b1, 1);
      hold(1'b0, 6);
      hold(1'b1, 20);
      settle();
      chk_eq("R8 long low", n_frm - b_frm, 1);

      // R11 message ends mid-byte
      b_rx = n_rx; b_frm = n_frm; b_pull = pull_cyc;
      hold(1'b0, 2);
      send_byte(8'hE1, 0);
      send_bits(mk_frame(8'h0F, 1'b0, 1'b0), 3, 0, 1);
      hold(1'b1, 12);
      settle();
      chk_eq("R11 truncation flag", n_frm - b_frm, 1);
      chk_eq("R11 no byte", n_rx - b_rx, 0);
      chk_eq("R11 no pull", pull_cyc - b_pull, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule